// File: doc/BRIEF.md
# I2C Register-Access Slave

This block is the serial front end of a register bank. It watches the two I2C bus lines with the system clock and finds the START, repeated START and STOP conditions. It decodes the 7-bit device address and then moves bytes between the bus master and an internal bank of registers. The bank has up to 128 entries, each 8 bits wide. The block only pulls SDA low, for acknowledge bits and for zero bits of read data. Board pull-ups provide the high level.

A write transfer has three parts: the device address with the direction bit clear, a pointer byte, and any number of data bytes. A read transfer first sets the pointer with a write, then sends a repeated START and the device address with the direction bit set. The slave then sends bytes until the master answers one of them with a not-acknowledge. In each pointer byte, the top bit decides whether the register pointer advances after every data byte of that transfer. The register bank is attached through a one-cycle synchronous read port and a strobe-based write port. Read data is requested ahead of time, so the first bit of each byte is ready when SCL falls.

Top module: `i2c_regport_slave`

## Requirements
- R1: After reset, `sda_drive_low`, `reg_wr_en` and `reg_rd_en` are 0 and `reg_addr` is 0.
- R2: The block answers the device address `{6'b101110, addr_lsb_strap}`. A 1 in the eighth bit (the LSB) of the address byte means read. On a match, the block holds SDA low for the whole ninth clock.
- R3: When the address byte does not match, the block does not acknowledge. It never drives SDA and makes no register access until the next START or STOP.
- R4: SDA falling while SCL is high is a START. SDA rising while SCL is high is a STOP. A START in any state, including in the middle of a byte, restarts address reception, and an unfinished byte is thrown away. A STOP returns the block to idle.
- R5: The byte that follows a write-direction address is acknowledged and read as a pointer byte. Bits [6:0] load the register pointer that appears on `reg_addr`. Bit 7 sets auto-increment for the rest of the transfer.
- R6: Every complete data byte received after the pointer byte produces one `reg_wr_en` pulse, with `reg_wdata` equal to the byte and `reg_addr` equal to the pointer. The byte is acknowledged. With auto-increment off, every byte goes to the same register.
- R7: With auto-increment on, the pointer goes up by one after each data byte, in both directions. It wraps from 7'h7F to 7'h00.
- R8: In a read-direction transfer, the block sends the register at the pointer, MSb first. SDA changes only while SCL is low, so it stays steady during each high phase.
- R9: After a read byte, an acknowledge from the master makes the block send the next byte: the same register, or the next one when auto-increment is on. A not-acknowledge makes the block release SDA and stay silent until the next START or STOP.
- R10: The pointer keeps its value from one transfer to the next. A read with no pointer byte first starts at the pointer left by the previous transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| addr_lsb_strap | input | 1 | Least significant bit of the device address |
| sda_drive_low | output | 1 | 1 pulls SDA low, 0 releases it |
| reg_wr_en | output | 1 | One-cycle register write strobe |
| reg_rd_en | output | 1 | One-cycle register read request |
| reg_addr | output | 7 | Register pointer used by both strobes |
| reg_wdata | output | 8 | Write data, valid while `reg_wr_en` is 1 |
| reg_rdata | input | 8 | Read data, returned the cycle after `reg_rd_en` |

## Verification
Most faults in the control state become visible at the pins within one bus byte.
- A wrong bit count or a wrong state after the eighth clock moves the acknowledge into the wrong clock. This shows up as a missing or misplaced low level in the ninth clock, or as a corrupted data byte.
- A wrong pointer or increment flag does not show at once. It appears as a write to the wrong register or a wrong read value, either in the next data byte or in the first byte of a later transfer.
- A block that misses a STOP or a START stays in the old state. Its acknowledge then goes missing, or it makes a stray write strobe in the next transfer.

// File: rtl/i2c_regport_pkg.sv
package i2c_regport_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEVADR,
        ST_DEVACK,
        ST_SUBADR,
        ST_SUBACK,
        ST_WRDATA,
        ST_WRACK,
        ST_RDDATA,
        ST_RDACK,
        ST_IGNORE
    } xfer_state_e;

endpackage

// File: rtl/i2c_line_sampler.sv
module i2c_line_sampler #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);
    localparam int PIPE_W  = SYNC_STAGES + 1;
    localparam int N_LINES = 2;
    localparam int IDX_SCL = 1;
    localparam int IDX_SDA = 0;

    logic [N_LINES-1:0] raw;
    logic [N_LINES-1:0] cur;
    logic [N_LINES-1:0] prv;

    assign raw = {scl_i, sda_i};

    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        logic [PIPE_W-1:0] pipe_d;
        logic [PIPE_W-1:0] pipe_q;

        always_comb begin
            pipe_d = {pipe_q[PIPE_W-2:0], raw[g]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe_q <= '1;
            else        pipe_q <= pipe_d;
        end

        assign cur[g] = pipe_q[PIPE_W-2];
        assign prv[g] = pipe_q[PIPE_W-1];
    end

    assign scl_lvl   = cur[IDX_SCL];
    assign sda_lvl   = cur[IDX_SDA];
    assign scl_rise  = cur[IDX_SCL] & ~prv[IDX_SCL];
    assign scl_fall  = ~cur[IDX_SCL] & prv[IDX_SCL];
    assign start_evt = cur[IDX_SCL] & prv[IDX_SCL] & prv[IDX_SDA] & ~cur[IDX_SDA];
    assign stop_evt  = cur[IDX_SCL] & prv[IDX_SCL] & ~prv[IDX_SDA] & cur[IDX_SDA];

    AST_EVENTS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({start_evt, stop_evt, scl_rise, scl_fall})) else $error("bus events overlap"); // R4

endmodule

// File: rtl/i2c_xfer_fsm.sv
module i2c_xfer_fsm
    import i2c_regport_pkg::*;
#(
    parameter int          ADDR_W      = 7,
    parameter int          DATA_W      = 8,
    parameter logic [5:0]  DEV_ADDR_HI = 6'b101110
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_lvl,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_evt,
    input  logic              stop_evt,
    input  logic              addr_lsb,
    output logic              drive_low,
    output logic              wr_en,
    output logic              rd_en,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] rdata
);
    localparam int CNT_W = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DATA_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DATA_W - 1);

    typedef struct packed {
        xfer_state_e       state;
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] sh;
        logic [ADDR_W-1:0] ptr;
        logic              inc;
        logic              rd_mode;
        logic              mnack;
        logic              drv;
        logic              rdreq;
        logic              load;
    } ctx_t;

    ctx_t q, d;
    logic wr_now;

    always_comb begin
        d      = q;
        wr_now = 1'b0;

        // read request pipeline: request one cycle, capture the next
        if (q.rdreq) begin
            d.rdreq = 1'b0;
            d.load  = 1'b1;
        end
        if (q.load) begin
            d.load = 1'b0;
            d.sh   = rdata;
        end

        unique case (q.state)
            ST_IDLE, ST_IGNORE: ;
            ST_DEVADR, ST_SUBADR, ST_WRDATA: begin
                if (scl_rise) begin
                    d.sh  = {q.sh[DATA_W-2:0], sda_lvl};
                    d.cnt = q.cnt + 1'b1;
                end else if (scl_fall && q.cnt == CNT_FULL) begin
                    d.cnt = '0;
                    if (q.state == ST_DEVADR) begin
                        if (q.sh[DATA_W-1:1] == {DEV_ADDR_HI, addr_lsb}) begin
                            d.drv     = 1'b1;
                            d.rd_mode = q.sh[0];
                            d.rdreq   = q.sh[0];
                            d.state   = ST_DEVACK;
                        end else begin
                            d.state = ST_IGNORE;
                        end
                    end else if (q.state == ST_SUBADR) begin
                        d.ptr   = q.sh[ADDR_W-1:0];
                        d.inc   = q.sh[DATA_W-1];
                        d.drv   = 1'b1;
                        d.state = ST_SUBACK;
                    end else begin
                        wr_now  = 1'b1;
                        d.ptr   = q.ptr + ADDR_W'(q.inc);
                        d.drv   = 1'b1;
                        d.state = ST_WRACK;
                    end
                end
            end
            ST_DEVACK: begin
                if (scl_fall) begin
                    d.cnt = '0;
                    if (q.rd_mode) begin
                        d.drv   = ~q.sh[DATA_W-1];
                        d.state = ST_RDDATA;
                    end else begin
                        d.drv   = 1'b0;
                        d.state = ST_SUBADR;
                    end
                end
            end
            ST_SUBACK, ST_WRACK: begin
                if (scl_fall) begin
                    d.drv   = 1'b0;
                    d.cnt   = '0;
                    d.state = ST_WRDATA;
                end
            end
            ST_RDDATA: begin
                if (scl_fall) begin
                    if (q.cnt == CNT_LAST) begin
                        d.drv   = 1'b0;
                        d.cnt   = '0;
                        d.ptr   = q.ptr + ADDR_W'(q.inc);
                        d.rdreq = 1'b1;
                        d.state = ST_RDACK;
                    end else begin
                        d.sh  = {q.sh[DATA_W-2:0], 1'b0};
                        d.drv = ~q.sh[DATA_W-2];
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
            ST_RDACK: begin
                if (scl_rise) begin
                    d.mnack = sda_lvl;
                end else if (scl_fall) begin
                    if (!q.mnack) begin
                        d.drv   = ~q.sh[DATA_W-1];
                        d.state = ST_RDDATA;
                    end else begin
                        d.state = ST_IGNORE;
                    end
                end
            end
            default: d.state = ST_IDLE;
        endcase

        if (start_evt || stop_evt) begin
            d.state = start_evt ? ST_DEVADR : ST_IDLE;
            d.cnt   = '0;
            d.drv   = 1'b0;
            d.rdreq = 1'b0;
            d.load  = 1'b0;
            d.mnack = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign drive_low = q.drv;
    assign wr_en     = wr_now;
    assign rd_en     = q.rdreq;
    assign reg_addr  = q.ptr;
    assign wdata     = q.sh;

    AST_IGNORE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_IGNORE) |-> (!q.drv && !wr_now)) else $error("drive while ignoring"); // R3
    AST_PTR_HOLD_NOINC: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state != ST_SUBADR && !q.inc) |=> $stable(q.ptr)) else $error("pointer moved"); // R6
    AST_WR_RD_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_now && q.rdreq)) else $error("write and read together"); // R6
    AST_RD_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
        q.rdreq |-> (q.state == ST_DEVACK || q.state == ST_RDACK)) else $error("stray read"); // R8

endmodule

// File: rtl/i2c_regport_slave.sv
module i2c_regport_slave #(
    parameter int         ADDR_W      = 7,
    parameter int         DATA_W      = 8,
    parameter int         SYNC_STAGES = 2,
    parameter logic [5:0] DEV_ADDR_HI = 6'b101110
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic              addr_lsb_strap,
    output logic              sda_drive_low,
    output logic              reg_wr_en,
    output logic              reg_rd_en,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    input  logic [DATA_W-1:0] reg_rdata
);
    logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_evt, stop_evt;

    i2c_line_sampler #(
        .SYNC_STAGES (SYNC_STAGES)
    ) sampler_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_lvl   (scl_lvl),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_evt (start_evt),
        .stop_evt  (stop_evt)
    );

    i2c_xfer_fsm #(
        .ADDR_W      (ADDR_W),
        .DATA_W      (DATA_W),
        .DEV_ADDR_HI (DEV_ADDR_HI)
    ) fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_evt (start_evt),
        .stop_evt  (stop_evt),
        .addr_lsb  (addr_lsb_strap),
        .drive_low (sda_drive_low),
        .wr_en     (reg_wr_en),
        .rd_en     (reg_rd_en),
        .reg_addr  (reg_addr),
        .wdata     (reg_wdata),
        .rdata     (reg_rdata)
    );

    AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_drive_low) |-> !scl_lvl) else $error("SDA moved with SCL high"); // R8

endmodule

// File: tb/i2c_regport_slave_tb_top.sv
module i2c_regport_slave_tb_top;
    localparam int Q = 6;
    localparam int H = 12;
    localparam int WATCHDOG = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       sda_m = 1'b1;
    logic       strap = 1'b1;
    logic       sda_line;
    logic       sda_oe, wr_en, rd_en;
    logic [6:0] addr;
    logic [7:0] wdata;
    logic [7:0] rdata = 8'h00;
    logic [7:0] mem [128];
    int         wr_cnt = 0;
    int         rd_cnt = 0;
    int         checks = 0;
    int         fails = 0;
    int         cyc = 0;
    bit         watch_oe = 1'b0;
    bit         oe_seen = 1'b0;
    bit         done = 1'b0;

    always #2 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    i2c_regport_slave dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .scl_i          (scl),
        .sda_i          (sda_line),
        .addr_lsb_strap (strap),
        .sda_drive_low  (sda_oe),
        .reg_wr_en      (wr_en),
        .reg_rd_en      (rd_en),
        .reg_addr       (addr),
        .reg_wdata      (wdata),
        .reg_rdata      (rdata)
    );

    always @(posedge clk) begin
        if (wr_en) begin
            mem[addr] <= wdata;
            wr_cnt    <= wr_cnt + 1;
        end
        if (rd_en) begin
            rdata  <= mem[addr];
            rd_cnt <= rd_cnt + 1;
        end
        if (watch_oe && sda_oe) oe_seen <= 1'b1;
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > WATCHDOG) begin
            fails = fails + 1;
            $display("FAIL watchdog: run hung, actual=%0d cycles expected<%0d", cyc, WATCHDOG);
            finish_run();
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wcyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wcyc(Q);
        scl = 1'b1;   wcyc(Q);
        sda_m = 1'b0; wcyc(Q);
        scl = 1'b0;   wcyc(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wcyc(Q);
        scl = 1'b1;   wcyc(Q);
        sda_m = 1'b1; wcyc(Q);
    endtask

    task automatic send_bits(input logic [7:0] b, input int nbits);
        for (int i = 7; i > 7 - nbits; i--) begin
            sda_m = b[i]; wcyc(Q);
            scl = 1'b1;   wcyc(H);
            scl = 1'b0;   wcyc(Q);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        send_bits(b, 8);
        sda_m = 1'b1; wcyc(Q);
        scl = 1'b1;   wcyc(2);
        ack = sda_line;
        wcyc(H - 4);
        if (sda_line != ack) ack = 1'b1;
        wcyc(2);
        scl = 1'b0;   wcyc(Q);
    endtask

    task automatic recv_byte(input logic nack, output logic [7:0] b, output bit steady);
        logic s1;
        steady = 1'b1;
        sda_m  = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wcyc(Q);
            scl = 1'b1; wcyc(2);
            s1 = sda_line;
            wcyc(H - 4);
            if (sda_line != s1) steady = 1'b0;
            b[i] = s1;
            wcyc(2);
            scl = 1'b0; wcyc(Q);
        end
        sda_m = nack; wcyc(Q);
        scl = 1'b1;   wcyc(H);
        scl = 1'b0;   wcyc(Q);
        sda_m = 1'b1;
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        chk(sda_oe == 1'b0, "R1 sda_drive_low", sda_oe, 0);
        chk(wr_en == 1'b0 && rd_en == 1'b0, "R1 strobes", {wr_en, rd_en}, 0);
        chk(addr == 7'h00, "R1 reg_addr", addr, 0);
    endtask

    task automatic t_write_single();
        logic a0, a1, a2;
        int w0 = wr_cnt;
        bus_start();
        send_byte(8'hBA, a0);
        send_byte(8'h10, a1);
        send_byte(8'h5A, a2);
        bus_stop();
        chk(a0 == 1'b0, "R2 device address ack", a0, 0);
        chk(a1 == 1'b0, "R5 pointer byte ack", a1, 0);
        chk(a2 == 1'b0 && mem[16] == 8'h5A, "R6 single write", mem[16], 8'h5A);
        chk(wr_cnt - w0 == 1 && addr == 7'h10, "R5 pointer held", addr, 7'h10);
    endtask

    task automatic t_write_noinc();
        logic a;
        int w0;
        mem[33] = 8'h00;
        w0 = wr_cnt;
        bus_start();
        send_byte(8'hBA, a);
        send_byte(8'h20, a);
        send_byte(8'h11, a);
        send_byte(8'h22, a);
        send_byte(8'h33, a);
        bus_stop();
        chk(mem[32] == 8'h33, "R6 same register", mem[32], 8'h33);
        chk(mem[33] == 8'h00 && wr_cnt - w0 == 3, "R6 three strobes no spill", wr_cnt - w0, 3);
    endtask

    task automatic t_write_wrap();
        logic a;
        bus_start();
        send_byte(8'hBA, a);
        send_byte(8'hFE, a);
        send_byte(8'hA1, a);
        send_byte(8'hA2, a);
        send_byte(8'hA3, a);
        bus_stop();
        chk(mem[126] == 8'hA1 && mem[127] == 8'hA2, "R7 increment", {mem[126], mem[127]}, 16'hA1A2);
        chk(mem[0] == 8'hA3 && addr == 7'h01, "R7 wrap to zero", {mem[0], 1'b0, addr}, 16'hA301);
    endtask

    task automatic t_read_inc();
        logic a;
        logic [7:0] b0, b1, b2;
        bit s0, s1, s2;
        mem[64] = 8'hC3; mem[65] = 8'h3C; mem[66] = 8'h96; mem[67] = 8'h5E;
        bus_start();
        send_byte(8'hBA, a);
        send_byte(8'hC0, a);
        bus_start();
        send_byte(8'hBB, a);
        chk(a == 1'b0, "R2 read address ack", a, 0);
        recv_byte(1'b0, b0, s0);
        recv_byte(1'b0, b1, s1);
        recv_byte(1'b1, b2, s2);
        chk(b0 == 8'hC3, "R8 first read byte", b0, 8'hC3);
        chk(b1 == 8'h3C && b2 == 8'h96, "R9 ack continues with increment", {b1, b2}, 16'h3C96);
        chk(s0 && s1 && s2, "R8 SDA steady while SCL high", {s0, s1, s2}, 3'b111);
        // after NACK: extra clocks, line must stay released
        watch_oe = 1'b1; oe_seen = 1'b0;
        send_bits(8'hFF, 2);
        bus_stop();
        watch_oe = 1'b0;
        chk(!oe_seen, "R9 released after NACK", oe_seen, 0);
    endtask

    task automatic t_read_nosub();
        logic a;
        logic [7:0] b;
        bit s;
        bus_start();
        send_byte(8'hBB, a);
        recv_byte(1'b1, b, s);
        bus_stop();
        chk(b == 8'h5E, "R10 pointer persists", b, 8'h5E);
    endtask

    task automatic t_read_noinc();
        logic a;
        logic [7:0] b0, b1;
        bit s;
        mem[65] = 8'h81;
        bus_start();
        send_byte(8'hBA, a);
        send_byte(8'h41, a);
        bus_start();
        send_byte(8'hBB, a);
        recv_byte(1'b0, b0, s);
        recv_byte(1'b1, b1, s);
        bus_stop();
        chk(b0 == 8'h81 && b1 == 8'h81, "R9 same register without increment", {b0, b1}, 16'h8181);
    endtask

    task automatic t_mismatch();
        logic a0, a1, a2;
        int w0 = wr_cnt;
        int r0 = rd_cnt;
        watch_oe = 1'b1; oe_seen = 1'b0;
        bus_start();
        send_byte(8'hB8, a0);
        send_byte(8'h12, a1);
        send_byte(8'h99, a2);
        bus_stop();
        watch_oe = 1'b0;
        chk(a0 == 1'b1, "R3 no ack on mismatch", a0, 1);
        chk(a1 == 1'b1 && a2 == 1'b1 && !oe_seen, "R3 silent afterwards", {a1, a2, oe_seen}, 3'b110);
        chk(wr_cnt == w0 && rd_cnt == r0, "R3 no register access", wr_cnt - w0, 0);
    endtask

    task automatic t_strap_low();
        logic a0, a1;
        strap = 1'b0;
        wcyc(4);
        bus_start();
        send_byte(8'hBA, a1);
        bus_stop();
        bus_start();
        send_byte(8'hB8, a0);
        send_byte(8'h13, a0);
        send_byte(8'h6D, a0);
        bus_stop();
        chk(a1 == 1'b1, "R2 strap 0 rejects x=1", a1, 1);
        chk(a0 == 1'b0 && mem[19] == 8'h6D, "R2 strap 0 accepts x=0", mem[19], 8'h6D);
        strap = 1'b1;
        wcyc(4);
    endtask

    task automatic t_restart_midbyte();
        logic a;
        mem[80] = 8'hEE;
        bus_start();
        send_byte(8'hBA, a);
        send_byte(8'hD0, a);
        send_bits(8'h00, 3);
        bus_start();
        send_byte(8'hBA, a);
        chk(a == 1'b0, "R4 repeated start accepted mid-byte", a, 0);
        send_byte(8'h51, a);
        send_byte(8'h77, a);
        bus_stop();
        chk(mem[80] == 8'hEE, "R4 partial byte dropped", mem[80], 8'hEE);
        chk(mem[81] == 8'h77, "R4 new transfer writes", mem[81], 8'h77);
        chk(sda_oe == 1'b0, "R4 idle after stop", sda_oe, 0);
    endtask

    initial begin
        for (int i = 0; i < 128; i++) mem[i] = 8'h00;
        wcyc(5);
        rst_n = 1'b1;
        wcyc(5);
        t_reset();
        t_write_single();
        t_write_noinc();
        t_write_wrap();
        t_read_inc();
        t_read_nosub();
        t_read_noinc();
        t_mismatch();
        t_strap_low();
        t_restart_midbyte();
        wcyc(10);
        finish_run();
    end

endmodule